// File: doc/BRIEF.md
# Linked Command List Sequencer

This block is the command unit of a network controller. It executes a chain of command blocks that software has laid out in memory. Each block begins with a command word carrying flags and an opcode, followed by a link word holding the offset of the next block. Offsets, including the first one, are added to a base address input to form byte addresses. The unit talks to memory through a word-wide request port, one word per request. Software drives it through two pulses: start, which takes its first offset from a pointer input, and resume.

For every block the unit reads the command word and the link, and runs the action. The station-address opcode reads two more words and loads a 48-bit station address. Every other opcode does nothing but complete. The unit then rewrites the command word with completion status. Finally the end-of-list and suspend flags decide whether it goes idle, suspends, or fetches the block that the link names. Completion of a flagged block raises an interrupt-request pulse. A second pulse marks every exit from the active state.

Top module: `cmd_list_seq`

## Requirements
- R1: While reset is held and after it is released, cu_state is 00 (idle), mem_req, cx_irq and cna_pulse are low, and station_addr is zero. The state codes are 00 idle, 01 suspended and 10 active.
- R2: A start pulse seen in idle or suspended makes the block address base_addr + host_ptr. The unit then reads the command word at that byte address and the link at +4. A start pulse seen while active is ignored.
- R3: Command word fields are: bit 31 end-of-list, bit 30 suspend, bit 29 interrupt request, and bits 18:16 the opcode. Opcode 001 reads the words at +8 and +12 and sets station_addr to {word(+12)[15:0], word(+8)}, so the first address byte sits in bits 7:0.
- R4: Opcodes 000 and 010 through 111 do no memory access besides the command word, link and status. They leave station_addr unchanged.
- R5: Each block ends with a write of the word at its own address. In that word, bits 31:16 are the command word's, bit 15 (complete) is 1, bit 13 (ok) is 1, and all other low bits are 0.
- R6: After the status write, end-of-list makes the unit idle. If end-of-list is clear, suspend makes it suspended. Otherwise it reads the next block at base_addr + link.
- R7: The status write of a block is acknowledged before any command-word read of the next block. The unit leaves the active state only on a status-write acknowledge.
- R8: A resume pulse while suspended re-reads the current block's link word at +4 and continues at base_addr + that value. A resume pulse while idle or active has no effect.
- R9: cx_irq is a one-cycle pulse in the cycle after the status-write acknowledge of a block whose interrupt-request bit is set.
- R10: cna_pulse is a one-cycle pulse in the first cycle after each exit from the active state.
- R11: mem_req stays high with mem_addr, mem_we and mem_wdata stable until mem_ack. No request is made outside the active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start | input | 1 | Start pulse |
| host_resume | input | 1 | Resume pulse |
| host_ptr | input | 32 | Offset of the first block, taken on start |
| base_addr | input | 32 | Base added to every block offset |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data (status word) |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| cu_state | output | 2 | 00 idle, 01 suspended, 10 active |
| cx_irq | output | 1 | Completion interrupt-request pulse |
| cna_pulse | output | 1 | Left-active pulse |
| station_addr | output | 48 | Loaded station address |

## Verification
The properties assume that mem_ack is only raised while mem_req is high, for at most one cycle per request, and with read data valid in that cycle. They also assume that start and resume are single-cycle pulses. The bench memory model acknowledges a pending request at most once and then drops the acknowledge for a cycle before it serves the next one. Host pulses are driven for exactly one clock. Every block offset the stimulus uses lands inside the model's 256-byte window.

// File: rtl/cls_pkg.sv
package cls_pkg;
  localparam int WORD_W   = 32;
  localparam int IA_BYTES = 6;
  localparam int IA_W     = 8 * IA_BYTES;

  // command word bit positions (full-word numbering)
  localparam int EL_BIT = 31;
  localparam int S_BIT  = 30;
  localparam int I_BIT  = 29;
  localparam int OP_LSB = 16;
  localparam int C_BIT  = 15;
  localparam int OK_BIT = 13;
  localparam int HI_LSB = 16;

  localparam logic [3:0] LINK_OFS = 4'd4;
  localparam logic [3:0] IA0_OFS  = 4'd8;
  localparam logic [3:0] IA1_OFS  = 4'd12;

  localparam logic [2:0] OP_NOP = 3'b000;
  localparam logic [2:0] OP_IA  = 3'b001;

  typedef enum logic [1:0] {
    CU_IDLE   = 2'b00,
    CU_SUSP   = 2'b01,
    CU_ACTIVE = 2'b10
  } cu_state_e;

  // completion word: upper half kept, complete and ok set, rest cleared
  function automatic logic [WORD_W-1:0] status_word(input logic [15:0] cmd_hi);
    logic [WORD_W-1:0] w;
    w = {cmd_hi, 16'h0000};
    w[C_BIT]  = 1'b1;
    w[OK_BIT] = 1'b1;
    return w;
  endfunction

  // block byte address from base and offset
  function automatic logic [WORD_W-1:0] block_target(input logic [WORD_W-1:0] base,
                                                     input logic [WORD_W-1:0] ofs);
    return base + ofs;
  endfunction

  // station address: first byte in the lowest bits
  function automatic logic [IA_W-1:0] assemble_ia(input logic [WORD_W-1:0] lo,
                                                  input logic [15:0] hi16);
    return {hi16, lo};
  endfunction
endpackage

// File: rtl/cls_fsm.sv
module cls_fsm
  import cls_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_start,
  input  logic              host_resume,
  input  logic [WORD_W-1:0] host_ptr,
  input  logic [WORD_W-1:0] base_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [1:0]        cu_state,
  output logic              ev_block_done,
  output logic              ev_leave_active,
  output logic              ev_ia_lo,
  output logic              ev_ia_hi,
  output logic              cmd_irq
);
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_SUSP, SQ_CMD, SQ_LINK, SQ_IA0, SQ_IA1, SQ_STAT, SQ_RELINK
  } seq_e;

  seq_e               st;
  logic [ADDR_W-1:0]  blk_addr;
  logic [15:0]        cmd_hi;
  logic [WORD_W-1:0]  link_off;
  logic [3:0]         ofs;
  logic [WORD_W-1:0]  start_tgt, link_tgt, relink_tgt;
  logic               flag_el, flag_s;
  logic [2:0]         opcode;

  assign flag_el = cmd_hi[EL_BIT-HI_LSB];
  assign flag_s  = cmd_hi[S_BIT-HI_LSB];
  assign cmd_irq = cmd_hi[I_BIT-HI_LSB];
  assign opcode  = cmd_hi[OP_LSB-HI_LSB +: 3];

  assign start_tgt  = block_target(base_addr, host_ptr);
  assign link_tgt   = block_target(base_addr, link_off);
  assign relink_tgt = block_target(base_addr, mem_rdata);

  always_comb begin
    case (st)
      SQ_LINK, SQ_RELINK: ofs = LINK_OFS;
      SQ_IA0:             ofs = IA0_OFS;
      SQ_IA1:             ofs = IA1_OFS;
      default:            ofs = 4'd0;
    endcase
  end

  assign mem_req   = (st != SQ_IDLE) && (st != SQ_SUSP);
  assign mem_we    = (st == SQ_STAT);
  assign mem_addr  = blk_addr + ADDR_W'(ofs);
  assign mem_wdata = status_word(cmd_hi);

  always_comb begin
    case (st)
      SQ_IDLE: cu_state = CU_IDLE;
      SQ_SUSP: cu_state = CU_SUSP;
      default: cu_state = CU_ACTIVE;
    endcase
  end

  assign ev_block_done   = (st == SQ_STAT) && mem_ack;
  assign ev_leave_active = ev_block_done && (flag_el || flag_s);
  assign ev_ia_lo        = (st == SQ_IA0) && mem_ack;
  assign ev_ia_hi        = (st == SQ_IA1) && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= SQ_IDLE;
      blk_addr <= '0;
      cmd_hi   <= '0;
      link_off <= '0;
    end else begin
      case (st)
        SQ_IDLE, SQ_SUSP: begin
          if (host_start) begin
            blk_addr <= start_tgt[ADDR_W-1:0];
            st       <= SQ_CMD;
          end else if (host_resume && st == SQ_SUSP) begin
            st <= SQ_RELINK;
          end
        end
        SQ_CMD: if (mem_ack) begin
          cmd_hi <= mem_rdata[WORD_W-1:HI_LSB];
          st     <= SQ_LINK;
        end
        SQ_LINK: if (mem_ack) begin
          link_off <= mem_rdata;
          st       <= (opcode == OP_IA) ? SQ_IA0 : SQ_STAT;
        end
        SQ_IA0: if (mem_ack) st <= SQ_IA1;
        SQ_IA1: if (mem_ack) st <= SQ_STAT;
        SQ_STAT: if (mem_ack) begin
          if (flag_el)     st <= SQ_IDLE;
          else if (flag_s) st <= SQ_SUSP;
          else begin
            blk_addr <= link_tgt[ADDR_W-1:0];
            st       <= SQ_CMD;
          end
        end
        SQ_RELINK: if (mem_ack) begin
          link_off <= mem_rdata;
          blk_addr <= relink_tgt[ADDR_W-1:0];
          st       <= SQ_CMD;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cls_station.sv
module cls_station
  import cls_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ia_lo,
  input  logic              ev_ia_hi,
  input  logic [WORD_W-1:0] rd_word,
  output logic [IA_W-1:0]   station_addr
);
  logic [WORD_W-1:0] lo_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_word      <= '0;
      station_addr <= '0;
    end else begin
      if (ev_ia_lo) lo_word <= rd_word;
      if (ev_ia_hi) station_addr <= assemble_ia(lo_word, rd_word[15:0]);
    end
  end
endmodule

// File: rtl/cls_events.sv
module cls_events (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_block_done,
  input  logic ev_leave_active,
  input  logic cmd_irq,
  output logic cx_irq,
  output logic cna_pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cx_irq    <= 1'b0;
      cna_pulse <= 1'b0;
    end else begin
      cx_irq    <= ev_block_done && cmd_irq;
      cna_pulse <= ev_leave_active;
    end
  end
endmodule

// File: rtl/cmd_list_seq.sv
module cmd_list_seq
  import cls_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_start,
  input  logic              host_resume,
  input  logic [31:0]       host_ptr,
  input  logic [31:0]       base_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [1:0]        cu_state,
  output logic              cx_irq,
  output logic              cna_pulse,
  output logic [47:0]       station_addr
);
  logic ev_block_done, ev_leave_active, ev_ia_lo, ev_ia_hi, cmd_irq;

  cls_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .host_start(host_start), .host_resume(host_resume),
    .host_ptr(host_ptr), .base_addr(base_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cu_state(cu_state),
    .ev_block_done(ev_block_done), .ev_leave_active(ev_leave_active),
    .ev_ia_lo(ev_ia_lo), .ev_ia_hi(ev_ia_hi), .cmd_irq(cmd_irq)
  );

  cls_station u_station (
    .clk(clk), .rst_n(rst_n),
    .ev_ia_lo(ev_ia_lo), .ev_ia_hi(ev_ia_hi),
    .rd_word(mem_rdata), .station_addr(station_addr)
  );

  cls_events u_events (
    .clk(clk), .rst_n(rst_n),
    .ev_block_done(ev_block_done), .ev_leave_active(ev_leave_active),
    .cmd_irq(cmd_irq), .cx_irq(cx_irq), .cna_pulse(cna_pulse)
  );
endmodule

// File: rtl/cls_checker.sv
module cls_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_start,
  input logic              host_resume,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic [1:0]        cu_state,
  input logic              cx_irq,
  input logic              cna_pulse
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)))
    else $error("R11 request dropped or changed before ack");

  assert_no_req_inactive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_state != 2'b10) |-> !mem_req)
    else $error("R11 request outside active state");

  assert_cna_on_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cu_state) == 2'b10 && cu_state != 2'b10) |-> cna_pulse)
    else $error("R10 exit without pulse");

  assert_cna_not_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cna_pulse |-> (cu_state != 2'b10 && $past(cu_state) == 2'b10))
    else $error("R10 spurious pulse");

  assert_cx_after_flagged_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cx_irq |-> $past(mem_we && mem_ack && mem_wdata[29]))
    else $error("R9 interrupt without flagged completion");

  assert_exit_after_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cu_state) == 2'b10 && cu_state != 2'b10) |-> $past(mem_we && mem_ack))
    else $error("R7 left active without status write");

  assert_resume_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_state == 2'b00 && host_resume && !host_start) |=> (cu_state == 2'b00))
    else $error("R8 resume while idle had effect");

  assert_el_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_ack && mem_wdata[31]) |=> (cu_state == 2'b00))
    else $error("R6 end-of-list did not idle");

  assert_s_susp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_ack && !mem_wdata[31] && mem_wdata[30]) |=> (cu_state == 2'b01))
    else $error("R6 suspend flag did not suspend");
endmodule

bind cmd_list_seq cls_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_resume(host_resume),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .cu_state(cu_state), .cx_irq(cx_irq), .cna_pulse(cna_pulse)
);

// File: tb/tb_cmd_list_seq.sv
module tb_cmd_list_seq;
  localparam int ADDR_W = 32;
  localparam logic [31:0] BASE = 32'h40;
  // {el, s, irq, opcode[2:0], expected state after first run[1:0]}
  localparam logic [7:0] VECS [8] = '{
    8'b100_000_00, 8'b101_001_00, 8'b011_010_01, 8'b000_001_00,
    8'b110_011_00, 8'b001_100_00, 8'b010_101_01, 8'b101_111_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic host_start = 0, host_resume = 0, mem_ack = 0;
  logic [31:0] host_ptr = 0, mem_rdata = 0, base_addr = BASE;
  logic mem_req, mem_we, cx_irq, cna_pulse;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [1:0] cu_state;
  logic [47:0] station_addr;

  cmd_list_seq #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_resume(host_resume),
    .host_ptr(host_ptr), .base_addr(base_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cu_state(cu_state), .cx_irq(cx_irq), .cna_pulse(cna_pulse), .station_addr(station_addr)
  );

  logic [31:0] mem [64];
  int checks = 0, errors = 0, cycles = 0;
  int fetch_cnt = 0, stat_cnt = 0, order_err = 0, cx_cnt = 0, cna_cnt = 0, req_cnt = 0;
  bit timed_out = 0;
  logic [47:0] exp_sta = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle: memory model, event counting, watchdog
  task automatic tick();
    int idx;
    @(negedge clk);
    cycles++;
    if (cycles > 150000) timed_out = 1;
    if (cx_irq) cx_cnt++;
    if (cna_pulse) cna_cnt++;
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      req_cnt++;
      idx = int'(mem_addr[7:2]);
      if (mem_we) begin
        mem[idx] = mem_wdata;
        stat_cnt++;
      end else begin
        if (mem_addr == 32'h40 || mem_addr == 32'h60 || mem_addr == 32'h80) begin
          if (fetch_cnt != stat_cnt) order_err++;
          fetch_cnt++;
        end
        mem_rdata = mem[idx];
      end
      mem_ack = 1;
    end
  endtask

  task automatic pulse_start(input logic [31:0] p);
    host_ptr = p; host_start = 1; tick(); host_start = 0;
  endtask
  task automatic pulse_resume();
    host_resume = 1; tick(); host_resume = 0;
  endtask
  task automatic wait_done();
    tick();
    while (cu_state == 2'b10 && !timed_out) tick();
  endtask
  task automatic clear_mem();
    for (int k = 0; k < 64; k++) mem[k] = '0;
    mem[24] = 32'h8000_0000;   // block B at 0x60: end-of-list NOP
    mem[32] = 32'h8000_0000;   // block C at 0x80: end-of-list NOP
  endtask

  initial begin
    clear_mem();
    repeat (3) tick();
    chk("R1 state in reset", cu_state, 2'b00);
    chk("R1 req in reset", mem_req, 0);
    chk("R1 pulses in reset", {cx_irq, cna_pulse}, 0);
    chk("R1 station in reset", station_addr, 0);
    rst_n = 1;
    tick();
    chk("R1 state after reset", cu_state, 2'b00);

    // table-driven single-list runs
    for (int v = 0; v < 8; v++) begin
      logic [7:0] e;
      logic el, s, ir;
      logic [2:0] op;
      logic [31:0] w0, ia2, ia3;
      int cx0, cna0;
      e = VECS[v];
      el = e[7]; s = e[6]; ir = e[5]; op = e[4:2];
      clear_mem();
      w0 = {el, s, ir, 10'b0, op, 16'h0000};
      ia2 = 32'h03020100 + 32'(v) * 32'h10101010;
      ia3 = 32'h0000_0504 + 32'(v) * 32'h0000_1111;
      mem[16] = w0; mem[17] = 32'h20; mem[18] = ia2; mem[19] = ia3;
      cx0 = cx_cnt; cna0 = cna_cnt;
      pulse_start(32'h0);
      wait_done();
      chk("R6 state after first run", cu_state, e[1:0]);
      chk("R2 R5 status at first block", mem[16], {w0[31:16], 16'hA000});
      if (op == 3'b001) begin
        exp_sta = {ia3[15:0], ia2};
        chk("R3 station loaded", station_addr, exp_sta);
      end else
        chk("R4 station unchanged", station_addr, exp_sta);
      if (!el && s) begin
        mem[17] = 32'h40;         // relink to C
        pulse_resume();
        wait_done();
        chk("R8 idle after resume", cu_state, 2'b00);
        chk("R8 relinked block done", mem[32][15], 1);
        chk("R8 stale link unused", mem[24][15], 0);
      end else if (!el)
        chk("R6 next block done", mem[24], 32'h8000_A000);
      else
        chk("R6 end-of-list stops", mem[24][15], 0);
      chk("R9 interrupt count", cx_cnt - cx0, ir);
      chk("R10 exit pulse count", cna_cnt - cna0, (s && !el) ? 2 : 1);
    end

    // resume while idle: no effect, no requests
    begin
      int r0;
      r0 = req_cnt;
      pulse_resume();
      repeat (4) tick();
      chk("R8 resume idle state", cu_state, 2'b00);
      chk("R11 R8 no request when idle", req_cnt - r0, 0);
    end

    // start while active is ignored
    begin
      int cna0;
      clear_mem();
      mem[16] = 32'h8001_0000; mem[17] = 32'h20;
      mem[18] = 32'hDDCCBBAA; mem[19] = 32'h0000_FFEE;
      cna0 = cna_cnt;
      pulse_start(32'h0);
      tick();
      pulse_start(32'h20);
      wait_done();
      chk("R2 first block done", mem[16], 32'h8001_A000);
      chk("R2 start during active ignored", mem[24][15], 0);
      chk("R3 station byte order", station_addr, 48'hFFEE_DDCCBBAA);
      chk("R10 single exit", cna_cnt - cna0, 1);
      exp_sta = 48'hFFEE_DDCCBBAA;
    end

    // start while suspended begins at the new pointer
    begin
      clear_mem();
      mem[16] = 32'h4000_0000; mem[17] = 32'h20;
      pulse_start(32'h0);
      wait_done();
      chk("R6 suspended", cu_state, 2'b01);
      pulse_start(32'h40);
      wait_done();
      chk("R2 start from suspend", mem[32][15], 1);
      chk("R2 old link not followed", mem[24][15], 0);
      chk("R4 station kept", station_addr, exp_sta);
    end

    chk("R7 status before next fetch", order_err, 0);
    if (timed_out) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule